// File: doc/BRIEF.md
# Four-Source Interrupt Flag Controller

This block keeps the interrupt enable and interrupt request flags for a small 4-bit processor. Four sources feed it: an ADC conversion-done pulse, two timer overflow pulses and a 4-bit input port. Software reads both flag nibbles and writes them over a nibble-wide write port. The `wr_sel` input picks which register a write goes to.

The port source watches its pins for edges. One control bit sets the active edge. When the pins use pull-high resistors, falling edges count. When they use pull-low resistors, rising edges count. A pin that is configured as an analog input can never raise a request.

The block drives an interrupt line whenever some pending request is also enabled. It also drives a wake line that brings the processor out of its halt state when an enabled ADC request is pending. Vector selection and context saving are done elsewhere.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the enable nibble and the request nibble both read 0, and `irq` and `wake` are low.
- R2: A write with `wr_en`=1 and `wr_sel`=0 loads `wr_data` into the enable nibble, and the new value reads back on `en_rd` after that clock edge. Bit 3 enables the ADC source, bit 2 timer 0, bit 1 timer 1 and bit 0 the port.
- R3: A one-cycle pulse on `adc_done`, `tmr0_evt` or `tmr1_evt` sets request bit 3, 2 or 1 respectively at that clock edge, whatever the enable bits hold.
- R4: A write with `wr_en`=1 and `wr_sel`=1 clears every request bit whose `wr_data` bit is 0. Request bits written with 1 keep their value, so a write can never set a request.
- R5: When a source event and a software clear of the same request bit fall in the same cycle, the bit ends up set.
- R6: With `pull_high`=1, a digital pin that reads 1 in one cycle and 0 in the next sets request bit 0 at that second edge. Rising transitions are ignored.
- R7: With `pull_high`=0, a digital pin that goes from 0 to 1 sets request bit 0. Falling transitions are ignored.
- R8: A pin whose `port_analog` bit is 1 raises no port request on any transition, and it does not stop other digital pins from raising one in the same cycle.
- R9: `irq` is 1 exactly when some request bit and its matching enable bit are both 1.
- R10: `wake` is 1 exactly when request bit 3 and enable bit 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 enable nibble, 1 request nibble |
| wr_data | input | 4 | Write data nibble |
| en_rd | output | 4 | Enable nibble read value |
| req_rd | output | 4 | Request nibble read value |
| adc_done | input | 1 | ADC conversion-done pulse |
| tmr0_evt | input | 1 | Timer 0 overflow pulse |
| tmr1_evt | input | 1 | Timer 1 overflow pulse |
| port_pins | input | 4 | Port pin levels, synchronous to clk |
| port_analog | input | 4 | Per-pin analog configuration, 1 masks the pin |
| pull_high | input | 1 | 1: pull-high with falling edges; 0: pull-low with rising edges |
| irq | output | 1 | Interrupt request to the processor |
| wake | output | 1 | Wake-up from halt |

## Verification
The bench fires a timer event in the same cycle as a software clear of that bit. A design where the clear wins would lose the bit and read 0 instead of 2.

It switches the polarity bit while the pins hold still. It also drives edges of the inactive direction. A detector that compares against the wrong level, or that treats a polarity change as an edge, would raise a port request that should not be there.

Transitions on analog-configured pins are driven alone and also together with a digital pin edge. A design without the mask would set bit 0 in the first case. A design that applies the mask to the whole port would miss the second case.

The bench writes ones to the request nibble and expects nothing to be set. It raises requests with their enables off and expects `irq` to stay low until the enable write. It also checks that `wake` follows only the ADC bit.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_SRC  = 4;
    localparam int PORT_W   = 4;
    // Bit positions shared by the enable and request nibbles
    localparam int SRC_ADC  = 3;
    localparam int SRC_TMR0 = 2;
    localparam int SRC_TMR1 = 1;
    localparam int SRC_PORT = 0;
endpackage

// File: rtl/irq_port_edge.sv
module irq_port_edge #(
    parameter int PW = irq_flag_pkg::PORT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pins_i,
    input  logic [PW-1:0] analog_i,
    input  logic          pull_high_i,
    output logic          evt_o
);
    typedef struct packed {
        logic [PW-1:0] prev;
        logic          vld;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [PW-1:0] hit;

    // Per-pin edge qualifier
    for (genvar g = 0; g < PW; g++) begin : g_pin
        always_comb begin
            if (!st_q.vld || analog_i[g]) begin
                hit[g] = 1'b0;
            end else if (pull_high_i) begin
                hit[g] = st_q.prev[g] & ~pins_i[g];
            end else begin
                hit[g] = ~st_q.prev[g] & pins_i[g];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pins_i;
        st_d.vld  = 1'b1;
        evt_o     = |hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: an event needs a changing pin that is configured digital
    assert_analog_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (|(~analog_i & (pins_i ^ st_q.prev))));

    // R6: in pull-high mode an event needs a digital pin going 1 -> 0
    assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && pull_high_i) |-> (|(~analog_i & st_q.prev & ~pins_i)));

    // R7: in pull-low mode an event needs a digital pin going 0 -> 1
    assert_rise_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !pull_high_i) |-> (|(~analog_i & ~st_q.prev & pins_i)));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = irq_flag_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr_i,
    input  logic         req_wr_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] req_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] req;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [N-1:0] keep;

    // Per-bit clear mask: a written 0 drops the bit, a written 1 keeps it
    for (genvar b = 0; b < N; b++) begin : g_bit
        assign keep[b] = req_wr_i ? wdata_i[b] : 1'b1;
    end

    always_comb begin
        st_d = st_q;
        if (en_wr_i) begin
            st_d.en = wdata_i;
        end
        // Hardware set is ORed after the clear, so it wins
        st_d.req = (st_q.req & keep) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign req_o = st_q.req;

    // R2: an enable write lands on the next cycle
    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_o == $past(wdata_i)));

    // R5: every source event is visible after its edge
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((req_o & $past(set_i)) == $past(set_i)));

    // R4: bits written 0 without an event are clear afterwards
    assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr_i |=> ((req_o & ~$past(wdata_i) & ~$past(set_i)) == '0));

    // R4: with no write and no event the requests hold
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_wr_i && set_i == '0) |=> $stable(req_o));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int PORT_W = irq_flag_pkg::PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [3:0]        wr_data,
    output logic [3:0]        en_rd,
    output logic [3:0]        req_rd,
    input  logic              adc_done,
    input  logic              tmr0_evt,
    input  logic              tmr1_evt,
    input  logic [PORT_W-1:0] port_pins,
    input  logic [PORT_W-1:0] port_analog,
    input  logic              pull_high,
    output logic              irq,
    output logic              wake
);
    import irq_flag_pkg::*;

    logic               port_evt;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] pend;

    irq_port_edge #(.PW(PORT_W)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (port_pins),
        .analog_i    (port_analog),
        .pull_high_i (pull_high),
        .evt_o       (port_evt)
    );

    always_comb begin
        src_set           = '0;
        src_set[SRC_ADC]  = adc_done;
        src_set[SRC_TMR0] = tmr0_evt;
        src_set[SRC_TMR1] = tmr1_evt;
        src_set[SRC_PORT] = port_evt;
    end

    irq_flag_bank #(.N(NUM_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr_i  (wr_en & ~wr_sel),
        .req_wr_i (wr_en & wr_sel),
        .wdata_i  (wr_data),
        .set_i    (src_set),
        .en_o     (en_rd),
        .req_o    (req_rd)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
        assign pend[s] = req_rd[s] & en_rd[s];
    end

    assign irq  = |pend;
    assign wake = pend[SRC_ADC];

    // R10: a wake-up is always an interrupt too
    assert_wake_implies_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);

    // R9: with no enables the interrupt line stays low
    assert_no_irq_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rd == '0) |-> !irq);
endmodule

// File: tb/irq_flag_ctrl_test.sv
module irq_flag_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] en_rd, req_rd;
    logic       adc_done = 1'b0, tmr0_evt = 1'b0, tmr1_evt = 1'b0;
    logic [3:0] port_pins = '0, port_analog = '0;
    logic       pull_high = 1'b0;
    logic       irq, wake;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_rd(en_rd), .req_rd(req_rd),
        .adc_done(adc_done), .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt),
        .port_pins(port_pins), .port_analog(port_analog),
        .pull_high(pull_high), .irq(irq), .wake(wake)
    );

    typedef struct packed {
        logic       we;
        logic       ws;
        logic [3:0] wd;
        logic       adc;
        logic       t0;
        logic       t1;
        logic [3:0] pins;
        logic [3:0] ana;
        logic       ph;
        logic [3:0] een;
        logic [3:0] ereq;
        logic       eirq;
        logic       ewake;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 22;
    // Fields: we ws wd adc t0 t1 pins ana ph | en req irq wake | requirement
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h0,4'h0,1'b0,1'b0, 4'd1},  // R1 idle
        '{1'b0,1'b0,4'h0,1'b1,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h0,4'h8,1'b0,1'b0, 4'd3},  // R3 adc, not enabled
        '{1'b1,1'b0,4'h8,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h8,4'h8,1'b1,1'b1, 4'd2},  // R2 enable adc
        '{1'b0,1'b0,4'h0,1'b0,1'b1,1'b0,4'h0,4'h0,1'b0, 4'h8,4'hC,1'b1,1'b1, 4'd3},  // R3 timer 0
        '{1'b1,1'b1,4'h7,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h8,4'h4,1'b0,1'b0, 4'd4},  // R4 clear bit 3
        '{1'b1,1'b0,4'h4,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h4,4'h4,1'b1,1'b0, 4'd9},  // R9 enable t0
        '{1'b1,1'b1,4'h0,1'b0,1'b0,1'b1,4'h0,4'h0,1'b0, 4'h4,4'h2,1'b0,1'b0, 4'd5},  // R5 set beats clear
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h1,4'h0,1'b0, 4'h4,4'h3,1'b0,1'b0, 4'd7},  // R7 rising
        '{1'b1,1'b0,4'h1,1'b0,1'b0,1'b0,4'h1,4'h0,1'b0, 4'h1,4'h3,1'b1,1'b0, 4'd9},  // R9 enable port
        '{1'b1,1'b1,4'hE,1'b0,1'b0,1'b0,4'h1,4'h0,1'b0, 4'h1,4'h2,1'b0,1'b0, 4'd4},  // R4 clear port
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0, 4'h1,4'h2,1'b0,1'b0, 4'd7},  // R7 falling ignored
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1, 4'h1,4'h2,1'b0,1'b0, 4'd6},  // R6 polarity swap
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h2,4'h0,1'b1, 4'h1,4'h2,1'b0,1'b0, 4'd6},  // R6 rising ignored
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1, 4'h1,4'h3,1'b1,1'b0, 4'd6},  // R6 falling sets
        '{1'b1,1'b1,4'hD,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1, 4'h1,4'h1,1'b1,1'b0, 4'd4},  // R4 ones keep
        '{1'b1,1'b1,4'hE,1'b0,1'b0,1'b0,4'h0,4'h0,1'b1, 4'h1,4'h0,1'b0,1'b0, 4'd4},  // R4 clear all
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h4,4'h4,1'b0, 4'h1,4'h0,1'b0,1'b0, 4'd8},  // R8 analog rise
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h4,1'b0, 4'h1,4'h0,1'b0,1'b0, 4'd8},  // R8
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h4,4'h4,1'b1, 4'h1,4'h0,1'b0,1'b0, 4'd8},  // R8
        '{1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'h0,4'h4,1'b1, 4'h1,4'h0,1'b0,1'b0, 4'd8},  // R8 analog fall
        '{1'b0,1'b0,4'h0,1'b1,1'b1,1'b1,4'h0,4'h4,1'b1, 4'h1,4'hE,1'b0,1'b0, 4'd3},  // R3 three sources
        '{1'b1,1'b0,4'h8,1'b0,1'b0,1'b0,4'h0,4'h4,1'b1, 4'h8,4'hE,1'b1,1'b1, 4'd10}  // R10 wake
    };

    task automatic chk(input string tag, input string what, input logic [3:0] act,
                       input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [3:0] e_en, input logic [3:0] e_req,
                           input logic e_irq, input logic e_wake);
        chk(tag, "en_rd", en_rd, e_en);
        chk(tag, "req_rd", req_rd, e_req);
        chk(tag, "irq", {3'b0, irq}, {3'b0, e_irq});
        chk(tag, "wake", {3'b0, wake}, {3'b0, e_wake});
    endtask

    task automatic apply(input vec_t v);
        wr_en = v.we; wr_sel = v.ws; wr_data = v.wd;
        adc_done = v.adc; tmr0_evt = v.t0; tmr1_evt = v.t1;
        port_pins = v.pins; port_analog = v.ana; pull_high = v.ph;
    endtask

    task automatic idle();
        wr_en = 1'b0; adc_done = 1'b0; tmr0_evt = 1'b0; tmr1_evt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1", 4'h0, 4'h0, 1'b0, 1'b0);      // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i]);
            @(negedge clk);
            chk_all($sformatf("R%0d", TBL[i].rq), TBL[i].een, TBL[i].ereq,
                    TBL[i].eirq, TBL[i].ewake);
        end

        // R1: reset in the middle of activity clears everything
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1", 4'h0, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R4: writing all ones to the request nibble sets nothing
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 4'hF;
        @(negedge clk);
        idle();
        chk_all("R4", 4'h0, 4'h0, 1'b0, 1'b0);

        // R8: analog pin masked while a digital pin edge in the same cycle counts
        port_analog = 4'h4; pull_high = 1'b0; port_pins = 4'h0;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'h1;
        @(negedge clk);
        idle();
        port_pins = 4'h5;
        @(negedge clk);
        chk_all("R8", 4'h1, 4'h1, 1'b1, 1'b0);

        // R10: an enabled timer request raises irq but not wake
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'h2; tmr1_evt = 1'b1;
        @(negedge clk);
        idle();
        chk_all("R10", 4'h2, 4'h3, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule